// File: doc/BRIEF.md
# Three-Phase Hall Commutation Decoder

This block turns three Hall sensor levels into six gate-enable signals for the external power stage of a three-phase brushless motor. Three of the outputs drive the high-side switches and three drive the low-side switches. In each commutation step exactly one high-side phase and one different low-side phase are enabled. The Hall levels are synchronized and debounced before they are decoded. A direction bit selects forward or reverse rotation by complementing the Hall code. A short blanking period after a direction change keeps both switches of a phase from conducting together.

Pulse-width chopping acts only on the high side. The high-side enable requires all of the following: the PWM carrier is high, the active-low external pulse input is low, undervoltage is clear, the stall inhibit is clear and no overcurrent cut is latched. The selected low-side output stays on for the whole step. The overcurrent cut is taken cycle by cycle. It is blanked for a set number of cycles after each carrier rising edge, so a recovery spike right after turn-on is ignored. A stop request and an invalid Hall code each turn off all six outputs. Oscillator, Hall amplifiers and current comparators are outside the block and arrive as logic levels.

Top module: `bldc_commutator`

## Requirements
- R1: With dir_rev_i low, the filtered Hall code {hall_i[2],hall_i[1],hall_i[0]} maps to gates as follows, where gate bit 0 is phase U, bit 1 is V and bit 2 is W: 101 gives high V and low U; 100 gives high W and low U; 110 gives high W and low V; 010 gives high U and low V; 011 gives high U and low W; 001 gives high V and low W.
- R2: At most one high-side output and at most one low-side output are high at any time.
- R3: Hall codes 000 and 111 drive all six outputs low.
- R4: With dir_rev_i high, the bitwise complement of the Hall code is applied to the R1 mapping.
- R5: When pwm_carrier_i is low, all high-side outputs are low and the selected low-side output stays high. A high-side output is high only while a low-side output is high.
- R6: When stop_i is high, all six outputs are low on the next clock.
- R7: When pwm_n_i is high, all high-side outputs are low and the low side is unaffected. High-side drive requires pwm_n_i to be low.
- R8: When uv_i is high, all high-side outputs are low and the low side is unaffected.
- R9: When stall_i is high, all high-side outputs are low and the low side is unaffected.
- R10: An overcurrent level on oc_i cuts the high side. The cut stays latched until the next rising edge of pwm_carrier_i. oc_i is ignored on the cycle of that rising edge and for the following BLANK_CYC cycles.
- R11: When dir_rev_i changes, all six outputs go low for at least DEAD_CYC cycles. After that the new direction's mapping is applied.
- R12: A new Hall code is accepted only after it has been seen on DEBOUNCE_N consecutive synchronized samples. Shorter glitches leave the outputs unchanged.
- R13: While reset is asserted, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hall_i | input | 3 | Raw Hall levels, bit 2 first sensor, bit 0 third sensor |
| dir_rev_i | input | 1 | 0 forward, 1 reverse |
| stop_i | input | 1 | 1 stops all drive |
| pwm_carrier_i | input | 1 | Internal carrier compare result, high = on phase |
| pwm_n_i | input | 1 | External pulse input, low enables high-side drive |
| uv_i | input | 1 | Undervoltage flag |
| oc_i | input | 1 | Overcurrent comparator flag |
| stall_i | input | 1 | Stall protection inhibit |
| gate_hi_o | output | 3 | High-side enables, bit 0 U, bit 1 V, bit 2 W |
| gate_lo_o | output | 3 | Low-side enables, bit 0 U, bit 1 V, bit 2 W |

## Verification
All eight Hall codes are swept in both directions and compared with the six-step table. The two all-equal codes are included in the sweep, and the reverse pass shows that complementing the code gives the opposite rotation sequence. Each high-side gating input is then toggled on its own while the decoded step is held. A correct result shows only the high side dropping, and tells a chopping fault apart from a fault that also drops the low side. The remaining tests cover the timed behaviour: a glitch one sample shorter than the debounce length, overcurrent inside and after the blanking window, and a direction flip checked both inside and after its dead window.

// File: rtl/bldc_pkg.sv
package bldc_pkg;
   localparam int PHASES = 3;
   localparam int PH_U = 0;
   localparam int PH_V = 1;
   localparam int PH_W = 2;

   typedef struct packed {
      logic [PHASES-1:0] hi;
      logic [PHASES-1:0] lo;
   } gate_pair_t;
endpackage

// File: rtl/bldc_hall_filter.sv
module bldc_hall_filter #(
   parameter int W           = 3,
   parameter int SYNC_STAGES = 2,
   parameter int DEBOUNCE_N  = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw_i,
   output logic [W-1:0] stable_o
);
   logic [W-1:0] sync_q [SYNC_STAGES];
   logic [W-1:0] sampled;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      end else begin
         sync_q[0] <= raw_i;
         for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      end
   end

   assign sampled = sync_q[SYNC_STAGES-1];

   generate
      if (DEBOUNCE_N == 1) begin : g_direct
         assign stable_o = sampled;
      end else begin : g_debounce
         localparam int CW = $clog2(DEBOUNCE_N + 1);
         logic [W-1:0]  cand_q;
         logic [W-1:0]  stable_q;
         logic [CW-1:0] run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cand_q   <= '0;
               stable_q <= '0;
               run_q    <= CW'(DEBOUNCE_N);
            end else if (sampled != cand_q) begin
               cand_q <= sampled;
               run_q  <= CW'(1);
            end else if (run_q == CW'(DEBOUNCE_N - 1)) begin
               stable_q <= cand_q;
               run_q    <= CW'(DEBOUNCE_N);
            end else if (run_q < CW'(DEBOUNCE_N)) begin
               run_q <= run_q + CW'(1);
            end
         end
         assign stable_o = stable_q;
      end
   endgenerate
endmodule

// File: rtl/bldc_step_decode.sv
module bldc_step_decode
   import bldc_pkg::*;
(
   input  logic [PHASES-1:0] code_i,
   input  logic              rev_i,
   output gate_pair_t        step_o
);
   logic [PHASES-1:0] eff;

   assign eff = rev_i ? ~code_i : code_i;

   always_comb begin
      step_o = '0;
      unique case (eff)
         3'b101: begin step_o.hi[PH_V] = 1'b1; step_o.lo[PH_U] = 1'b1; end
         3'b100: begin step_o.hi[PH_W] = 1'b1; step_o.lo[PH_U] = 1'b1; end
         3'b110: begin step_o.hi[PH_W] = 1'b1; step_o.lo[PH_V] = 1'b1; end
         3'b010: begin step_o.hi[PH_U] = 1'b1; step_o.lo[PH_V] = 1'b1; end
         3'b011: begin step_o.hi[PH_U] = 1'b1; step_o.lo[PH_W] = 1'b1; end
         3'b001: begin step_o.hi[PH_V] = 1'b1; step_o.lo[PH_W] = 1'b1; end
         default: step_o = '0;
      endcase
   end
endmodule

// File: rtl/bldc_oc_limiter.sv
module bldc_oc_limiter #(
   parameter int BLANK_CYC = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic carrier_i,
   input  logic oc_i,
   output logic cut_o
);
   localparam int BW = $clog2(BLANK_CYC + 1);

   logic          carrier_q;
   logic          rise;
   logic [BW-1:0] blank_q;

   assign rise = carrier_i & ~carrier_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         carrier_q <= 1'b0;
         blank_q   <= '0;
         cut_o     <= 1'b0;
      end else begin
         carrier_q <= carrier_i;
         if (rise) begin
            blank_q <= BW'(BLANK_CYC);
            cut_o   <= 1'b0;
         end else begin
            if (blank_q != '0) blank_q <= blank_q - BW'(1);
            else if (oc_i)     cut_o   <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/bldc_dir_guard.sv
module bldc_dir_guard #(
   parameter int DEAD_CYC = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_i,
   output logic dir_o,
   output logic guard_o
);
   localparam int DW = $clog2(DEAD_CYC + 1);

   logic [DW-1:0] dead_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dead_q <= '0;
         dir_o  <= 1'b0;
      end else if (dead_q != '0) begin
         dead_q <= dead_q - DW'(1);
         if (dead_q == DW'(1)) dir_o <= dir_i;
      end else if (dir_i != dir_o) begin
         dead_q <= DW'(DEAD_CYC);
      end
   end

   assign guard_o = (dead_q != '0) || (dir_i != dir_o);
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
   import bldc_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DEBOUNCE_N  = 4,
   parameter int BLANK_CYC   = 50,
   parameter int DEAD_CYC    = 100
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] hall_i,
   input  logic       dir_rev_i,
   input  logic       stop_i,
   input  logic       pwm_carrier_i,
   input  logic       pwm_n_i,
   input  logic       uv_i,
   input  logic       oc_i,
   input  logic       stall_i,
   output logic [2:0] gate_hi_o,
   output logic [2:0] gate_lo_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DEBOUNCE_N < 1) begin : g_bad_deb
         $error("DEBOUNCE_N must be at least 1");
      end
      if (BLANK_CYC < 1) begin : g_bad_blank
         $error("BLANK_CYC must be at least 1");
      end
      if (DEAD_CYC < 1) begin : g_bad_dead
         $error("DEAD_CYC must be at least 1");
      end
   endgenerate

   logic [PHASES-1:0] hall_filt;
   logic              dir_applied;
   logic              dead_active;
   logic              oc_cut;
   gate_pair_t        step;
   logic              drive_ok;
   logic              hs_ok;
   logic [PHASES-1:0] hi_next;
   logic [PHASES-1:0] lo_next;

   bldc_hall_filter #(
      .W(PHASES), .SYNC_STAGES(SYNC_STAGES), .DEBOUNCE_N(DEBOUNCE_N)
   ) u_filter (
      .clk(clk), .rst_n(rst_n), .raw_i(hall_i), .stable_o(hall_filt)
   );

   bldc_dir_guard #(.DEAD_CYC(DEAD_CYC)) u_guard (
      .clk(clk), .rst_n(rst_n), .dir_i(dir_rev_i),
      .dir_o(dir_applied), .guard_o(dead_active)
   );

   bldc_oc_limiter #(.BLANK_CYC(BLANK_CYC)) u_oc (
      .clk(clk), .rst_n(rst_n), .carrier_i(pwm_carrier_i),
      .oc_i(oc_i), .cut_o(oc_cut)
   );

   bldc_step_decode u_dec (
      .code_i(hall_filt), .rev_i(dir_applied), .step_o(step)
   );

   assign drive_ok = ~stop_i & ~dead_active;
   assign hs_ok    = pwm_carrier_i & ~pwm_n_i & ~uv_i & ~stall_i & ~oc_cut;
   assign hi_next  = step.hi & {PHASES{drive_ok & hs_ok}};
   assign lo_next  = step.lo & {PHASES{drive_ok}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_hi_o <= '0;
         gate_lo_o <= '0;
      end else begin
         gate_hi_o <= hi_next;
         gate_lo_o <= lo_next;
      end
   end
endmodule

// File: rtl/bldc_commutator_chk.sv
module bldc_commutator_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       stop_i,
   input logic       pwm_carrier_i,
   input logic       pwm_n_i,
   input logic       uv_i,
   input logic       stall_i,
   input logic [2:0] gate_hi_o,
   input logic [2:0] gate_lo_o,
   input logic [2:0] hall_filt,
   input logic       dead_active,
   input logic       oc_cut
);
   a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gate_hi_o) && $onehot0(gate_lo_o));

   a_r2_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_hi_o & gate_lo_o) == 3'b000);

   a_r3_invalid_off: assert property (@(posedge clk) disable iff (!rst_n)
      (hall_filt == 3'b000 || hall_filt == 3'b111) |=> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000));

   a_r5_carrier_chop: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_carrier_i |=> gate_hi_o == 3'b000);

   a_r5_hi_needs_lo: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_hi_o != 3'b000) |-> (gate_lo_o != 3'b000));

   a_r6_stop_off: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000));

   a_r7_ext_pwm: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_n_i |=> gate_hi_o == 3'b000);

   a_r8_uv: assert property (@(posedge clk) disable iff (!rst_n)
      uv_i |=> gate_hi_o == 3'b000);

   a_r9_stall: assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |=> gate_hi_o == 3'b000);

   a_r10_oc_cut: assert property (@(posedge clk) disable iff (!rst_n)
      oc_cut |=> gate_hi_o == 3'b000);

   a_r11_dead_off: assert property (@(posedge clk) disable iff (!rst_n)
      dead_active |=> (gate_hi_o == 3'b000 && gate_lo_o == 3'b000));
endmodule

bind bldc_commutator bldc_commutator_chk u_chk (
   .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .pwm_carrier_i(pwm_carrier_i),
   .pwm_n_i(pwm_n_i), .uv_i(uv_i), .stall_i(stall_i),
   .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o), .hall_filt(hall_filt),
   .dead_active(dead_active), .oc_cut(oc_cut)
);

// File: tb/bldc_commutator_test.sv
`timescale 1ns/1ps
module bldc_commutator_test;
   localparam int SYNC = 2;
   localparam int DEB  = 3;
   localparam int BLNK = 4;
   localparam int DEAD = 5;
   localparam int SETTLE = SYNC + DEB + DEAD + 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] hall = 3'b101;
   logic dir = 1'b0, stop = 1'b0, carrier = 1'b1, pwm_n = 1'b0;
   logic uv = 1'b0, oc = 1'b0, stall = 1'b0;
   logic [2:0] ghi, glo;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bldc_commutator #(.SYNC_STAGES(SYNC), .DEBOUNCE_N(DEB),
                     .BLANK_CYC(BLNK), .DEAD_CYC(DEAD)) uut (
      .clk(clk), .rst_n(rst_n), .hall_i(hall), .dir_rev_i(dir), .stop_i(stop),
      .pwm_carrier_i(carrier), .pwm_n_i(pwm_n), .uv_i(uv), .oc_i(oc),
      .stall_i(stall), .gate_hi_o(ghi), .gate_lo_o(glo));

   // {hi, lo}; bit 0 U, bit 1 V, bit 2 W
   function automatic logic [5:0] table_gates(input logic [2:0] code, input logic rev);
      logic [2:0] c;
      c = rev ? ~code : code;
      case (c)
         3'b101:  return {3'b010, 3'b001};
         3'b100:  return {3'b100, 3'b001};
         3'b110:  return {3'b100, 3'b010};
         3'b010:  return {3'b001, 3'b010};
         3'b011:  return {3'b001, 3'b100};
         3'b001:  return {3'b010, 3'b100};
         default: return 6'b0;
      endcase
   endfunction

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [2:0] ehi, input logic [2:0] elo);
      checks++;
      if (ghi !== ehi || glo !== elo) begin
         fails++;
         $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b", req, ghi, glo, ehi, elo);
      end
   endtask

   initial begin
      logic [5:0] e;
      @(negedge clk);
      check("R13 reset", 3'b000, 3'b000);
      wait_cyc(2);
      check("R13 reset held", 3'b000, 3'b000);
      rst_n = 1'b1;

      // R1 / R3 / R4 sweep
      for (int d = 0; d < 2; d++) begin
         for (int c = 0; c < 8; c++) begin
            dir  = d[0];
            hall = c[2:0];
            wait_cyc(SETTLE);
            e = table_gates(c[2:0], d[0]);
            check(d == 0 ? ((c == 0 || c == 7) ? "R3 fwd" : "R1 fwd")
                         : ((c == 0 || c == 7) ? "R3 rev" : "R4 rev"), e[5:3], e[2:0]);
         end
      end

      // high-side gating, code 101 forward: hi V, lo U
      dir = 1'b0; hall = 3'b101; wait_cyc(SETTLE);
      check("R1 base", 3'b010, 3'b001);
      carrier = 1'b0; wait_cyc(2);
      check("R5 carrier low", 3'b000, 3'b001);
      carrier = 1'b1; wait_cyc(2);
      check("R5 carrier back", 3'b010, 3'b001);
      pwm_n = 1'b1; wait_cyc(2);
      check("R7 pwm_n high", 3'b000, 3'b001);
      pwm_n = 1'b0; wait_cyc(2);
      uv = 1'b1; wait_cyc(2);
      check("R8 undervoltage", 3'b000, 3'b001);
      uv = 1'b0; wait_cyc(2);
      stall = 1'b1; wait_cyc(2);
      check("R9 stall", 3'b000, 3'b001);
      stall = 1'b0; wait_cyc(2);
      stop = 1'b1; wait_cyc(2);
      check("R6 stop", 3'b000, 3'b000);
      stop = 1'b0; wait_cyc(2);
      check("R6 restart", 3'b010, 3'b001);

      // R12 debounce: glitch of DEB-1 samples ignored
      hall = 3'b100; wait_cyc(DEB - 1);
      hall = 3'b101; wait_cyc(SETTLE);
      check("R12 glitch ignored", 3'b010, 3'b001);
      hall = 3'b100; wait_cyc(SYNC + DEB + 3);
      check("R12 accepted", 3'b100, 3'b001);
      hall = 3'b101; wait_cyc(SETTLE);

      // R10 overcurrent blanking and latch
      carrier = 1'b0; wait_cyc(2);
      carrier = 1'b1; oc = 1'b1; wait_cyc(BLNK);
      oc = 1'b0; wait_cyc(2);
      check("R10 blanked", 3'b010, 3'b001);
      wait_cyc(BLNK + 2);
      oc = 1'b1; wait_cyc(1);
      oc = 1'b0; wait_cyc(3);
      check("R10 latched", 3'b000, 3'b001);
      wait_cyc(3);
      check("R10 still latched", 3'b000, 3'b001);
      carrier = 1'b0; wait_cyc(2);
      carrier = 1'b1; wait_cyc(2);
      check("R10 cleared on rise", 3'b010, 3'b001);

      // R11 dead time on direction flip
      dir = 1'b1; wait_cyc(2);
      check("R11 dead early", 3'b000, 3'b000);
      wait_cyc(DEAD - 2);
      check("R11 dead late", 3'b000, 3'b000);
      wait_cyc(4);
      check("R11 new direction", 3'b001, 3'b010);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: hi=%b lo=%b expected run to complete", ghi, glo);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule